// File: doc/BRIEF.md
# Wrapping Position Threshold Comparator

This block decides whether a feedback position has reached a target position when both live on a counter that wraps around. A plain signed or unsigned compare gives the wrong answer as soon as the two values straddle a wrap point. The block instead splits the counter cycle into four quadrants, taken from the two most significant bits of each operand, and orders the operands by which quadrant is ahead of the other.

Operands in the same quadrant are ordered by an unsigned compare of their full values. Operands in neighbouring quadrants are ordered by the quadrant step. Operands half a cycle apart are ambiguous, so the block reports no decision for them. A downstream trigger uses `fb_ge` for forward motion and `fb_lt` for reverse motion, and it acts only while `cmp_valid` is high. Targets must stay within half the counter span of the feedback value. A target three quarters of a cycle away reads as a quarter of a cycle in the other direction.

The datapath width is a parameter from 32 to 64 bits. A 32-bit secondary position can be compared after it is left-justified into the datapath. A parameter adds an optional output register.

Top module: `quad_pos_cmp`

## Requirements
- R1: When `fb_pos` and the target are in the same quadrant (equal top two bits), `cmp_valid`=1, `fb_ge`=1 when `fb_pos` >= target (unsigned, full width), and `fb_lt`=1 otherwise.
- R2: When the feedback quadrant is one step ahead of the target quadrant, modulo 4 (so feedback quadrant 0 against target quadrant 3), then `fb_ge`=1, `fb_lt`=0 and `cmp_valid`=1.
- R3: When the feedback quadrant is one step behind the target quadrant, modulo 4, then `fb_lt`=1, `fb_ge`=0 and `cmp_valid`=1.
- R4: When the two quadrants differ by two, `cmp_valid`, `fb_ge` and `fb_lt` are all 0.
- R5: `fb_ge` and `fb_lt` are never high together, and `cmp_valid` equals `fb_ge` OR `fb_lt`.
- R6: Only `tgt_pos[W-1:0]` is used. Bits of `tgt_pos` at and above position W have no effect on the outputs.
- R7: With `sec_en`=1, the comparator uses `sec_pos` shifted left by W-32 as the feedback and `tgt_pos[31:0]` shifted left by W-32 as the target. `fb_pos` is then ignored.
- R8: With `OUT_REG`=1, the outputs reflect the inputs sampled at the previous rising clock edge, and they are 0 while `rst_n` is low. With `OUT_REG`=0, the outputs follow the inputs with no clock.
- R9: Value 1 compares as greater-or-equal to all-ones, and 0x7FF...F compares as less than 0x800...0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| fb_pos | input | W | Primary feedback position |
| tgt_pos | input | 64 | Target position; bits above W ignored |
| sec_pos | input | 32 | Secondary feedback position, left-justified when selected |
| sec_en | input | 1 | Selects the left-justified secondary path |
| fb_ge | output | 1 | Feedback at or past target |
| fb_lt | output | 1 | Feedback before target |
| cmp_valid | output | 1 | Decision meaningful (quadrants not opposite) |

## Verification
Two orderings can decide the same cycle's result: the quadrant-step rule and the same-quadrant magnitude compare. The boundary where one rule hands over to the other is the risky spot. The bench drives operand pairs that sit one count apart across every quadrant edge, including the unsigned and signed wrap points. It also drives equal values at the first count of each quadrant. A behavioural model built from integer arithmetic predicts each result every cycle. Both a 64-bit registered instance and a 32-bit combinational instance are judged against that model, and in the narrow instance the upper target bits are deliberately corrupted.

// File: rtl/quad_pos_cmp.sv
module quad_pos_cmp #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fb_pos,
  input  logic [63:0]  tgt_pos,
  input  logic [31:0]  sec_pos,
  input  logic         sec_en,
  output logic         fb_ge,
  output logic         fb_lt,
  output logic         cmp_valid
);
  localparam int SH = W - 32;

  logic [W-1:0] a, b;
  logic [1:0]   qa, qb, qd;
  logic         ge_c, lt_c, vld_c;

  assign a  = sec_en ? (W'(sec_pos) << SH) : fb_pos;
  assign b  = sec_en ? (W'(tgt_pos[31:0]) << SH) : tgt_pos[W-1:0];
  assign qa = a[W-1:W-2];
  assign qb = b[W-1:W-2];
  assign qd = qa - qb;

  always_comb begin
    ge_c  = 1'b0;
    lt_c  = 1'b0;
    vld_c = 1'b1;
    case (qd)
      2'd0: begin ge_c = (a >= b); lt_c = (a < b); end
      2'd1: ge_c = 1'b1;
      2'd3: lt_c = 1'b1;
      default: vld_c = 1'b0;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fb_ge     <= 1'b0;
          fb_lt     <= 1'b0;
          cmp_valid <= 1'b0;
        end else begin
          fb_ge     <= ge_c;
          fb_lt     <= lt_c;
          cmp_valid <= vld_c;
        end
      end
    end else begin : g_comb
      assign fb_ge     = ge_c;
      assign fb_lt     = lt_c;
      assign cmp_valid = vld_c;
    end
  endgenerate
endmodule

// File: rtl/quad_pos_cmp_chk.sv
module quad_pos_cmp_chk #(
  parameter int W       = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] fb_pos,
  input logic [63:0]  tgt_pos,
  input logic [31:0]  sec_pos,
  input logic         sec_en,
  input logic         fb_ge,
  input logic         fb_lt,
  input logic         cmp_valid
);
  logic opp, same_val;
  assign opp      = !sec_en && ((fb_pos[W-1:W-2] ^ tgt_pos[W-1:W-2]) == 2'b10);
  assign same_val = !sec_en && (fb_pos == tgt_pos[W-1:0]);

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fb_ge && fb_lt));

  // R5
  vld_sum_chk: assert property (@(posedge clk) disable iff (!rst_n) cmp_valid == (fb_ge || fb_lt));

  generate
    if (OUT_REG) begin : g_r
      // R4
      opp_chk: assert property (@(posedge clk) disable iff (!rst_n) opp |=> !cmp_valid);
      // R1
      eq_chk: assert property (@(posedge clk) disable iff (!rst_n) same_val |=> fb_ge);
    end else begin : g_c
      // R4
      opp_chk: assert property (@(posedge clk) disable iff (!rst_n) opp |-> !cmp_valid);
      // R1
      eq_chk: assert property (@(posedge clk) disable iff (!rst_n) same_val |-> fb_ge);
    end
  endgenerate
endmodule

bind quad_pos_cmp quad_pos_cmp_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_quad_pos_cmp.sv
module tb_quad_pos_cmp;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] fb = '0, tg = '0;
  logic [31:0] sp = '0;
  logic        se = 1'b0;
  logic        ge_w, lt_w, v_w, ge_n, lt_n, v_n;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  quad_pos_cmp #(.W(64), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .fb_pos(fb), .tgt_pos(tg), .sec_pos(sp), .sec_en(se),
    .fb_ge(ge_w), .fb_lt(lt_w), .cmp_valid(v_w));

  quad_pos_cmp #(.W(32), .OUT_REG(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .fb_pos(fb[31:0]), .tgt_pos(tg), .sec_pos(sp), .sec_en(se),
    .fb_ge(ge_n), .fb_lt(lt_n), .cmp_valid(v_n));

  function automatic logic [2:0] model(longint unsigned f, longint unsigned t,
                                       int w, bit us, longint unsigned s);
    longint unsigned m, qa, qb, d;
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
    if (us) begin
      f = s << (w - 32);
      t = (t & 64'hFFFF_FFFF) << (w - 32);
    end
    f = f & m;
    t = t & m;
    qa = (f >> (w - 2)) % 4;
    qb = (t >> (w - 2)) % 4;
    d  = (qa + 4 - qb) % 4;
    if (d == 0) return (f >= t) ? 3'b110 : 3'b101;
    if (d == 1) return 3'b110;
    if (d == 3) return 3'b101;
    return 3'b000;
  endfunction

  function automatic string rtag(longint unsigned f, longint unsigned t, int w, bit us);
    longint unsigned m, qa, qb, d;
    if (us) return "R7";
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
    qa = ((f & m) >> (w - 2)) % 4;
    qb = ((t & m) >> (w - 2)) % 4;
    d  = (qa + 4 - qb) % 4;
    case (d)
      0: return "R1";
      1: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp || act[1] && act[0]) begin
      n_fail++;
      $display("FAIL %s/R5 {valid,ge,lt} act=%b exp=%b fb=%h tg=%h", tag, act, exp, fb, tg);
    end
  endtask

  task automatic step(logic [63:0] f, logic [63:0] t, logic [31:0] s, bit u, string tag);
    logic [2:0] ew, en;
    string tw, tn;
    @(negedge clk);
    fb = f; tg = t; sp = s; se = u;
    ew = model(f, t, 64, u, s);
    en = model(f & 64'hFFFF_FFFF, t, 32, u, s);
    tw = (tag == "") ? rtag(f, t, 64, u) : tag;
    tn = (tag == "") ? rtag(f, t, 32, u) : tag;
    #1 chk({tn, " R8 comb"}, {v_n, ge_n, lt_n}, en);
    @(posedge clk);
    #1 chk({tw, " R8 reg"}, {v_w, ge_w, lt_w}, ew);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog expired");
          $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    fb = 64'h4000_0000_0000_0000; tg = 64'h0;
    repeat (3) @(negedge clk);
    chk("R8 reset", {v_w, ge_w, lt_w}, 3'b000);
    rst_n = 1'b1;

    step(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R9");
    step(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 0, "R9");
    step(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "");
    step(64'h1234, 64'h1234, 0, 0, "");
    step(64'h1233, 64'h1234, 0, 0, "");
    step(64'h0, 64'h8000_0000_0000_0000, 0, 0, "");
    step(64'hC000_0000_0000_0000, 64'h4000_0000_0000_0000, 0, 0, "");
    for (int q = 0; q < 4; q++) begin
      logic [63:0] e;
      e = 64'(q) << 62;
      step(e, e, 0, 0, "");
      step(e, e - 1, 0, 0, "");
      step(e - 1, e, 0, 0, "");
      step(e | 32'h4000_0000, e, 0, 0, "");
      step(e | 32'h8000_0000, (e & 64'hFFFF_FFFF_0000_0000) | 64'h4000_0000, 0, 0, "");
    end
    // R6: upper target bits corrupted on the 32-bit instance
    step(64'h0000_0000_0000_0010, 64'hDEAD_BEEF_0000_0010, 0, 0, "R6");
    step(64'h0000_0000_4000_0000, 64'h5555_AAAA_3FFF_FFFF, 0, 0, "R6");
    step(64'h0000_0000_1000_0000, 64'hFFFF_FFFF_9000_0000, 0, 0, "R6");
    // R7: secondary path, fb_pos must not matter
    step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 32'h0000_0002, 1, "R7");
    step(64'h0, 64'h0000_0000_FFFF_FFFF, 32'h0000_0001, 1, "R7");
    step(64'h1, 64'h0000_0000_8000_0000, 32'h7FFF_FFFF, 1, "R7");
    step(64'h5, 64'h0000_0000_0000_0000, 32'h8000_0000, 1, "R7");
    for (int i = 0; i < 400; i++) begin
      logic [63:0] f, t;
      f = {$urandom, $urandom};
      t = (i % 3 == 0) ? f + 64'($urandom % 5) - 2 : {$urandom, $urandom};
      if (i % 7 == 0) t = f ^ (64'd1 << 63);
      step(f, t, $urandom, (i % 11 == 0), "");
    end
    // R8: reset mid-run clears the register
    @(negedge clk);
    fb = 64'h10; tg = 64'h1;
    rst_n = 1'b0;
    #1 chk("R8 async reset", {v_w, ge_w, lt_w}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    step(64'h10, 64'h1, 0, 0, "");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule